// File: doc/BRIEF.md
# Seconds Counter with Dual Alarm Flags

This block keeps time as a 32-bit count of seconds and raises an interrupt when the count reaches either of two programmed compare values. A separate prescaler supplies a one-cycle enable once per second, and on each such enable the count advances by one. A simple word-addressed register bus writes and reads every register: the count, both compare values, one configuration word per alarm, a sticky status word, a calibration word that is only stored, and a test word that tells software whether the clock has been set up since reset.

Each register write is followed by a settling window, and a busy output stays high for the whole window. During that window the bus handshake holds off further writes: `ready` goes low and a write waits until it rises again. Software can issue writes of zero to the status word before a real write. Those writes change nothing and do not open a settling window.

Top module: `rtc_alarm_core`

## Requirements
- R1: After reset the count, both compare values, both configuration words, the calibration word and both status flags read 0. The test word reads TEST_INIT (0xA5) in bits [7:0], `uninit` is 1, and `busy` and `irq` are 0.
- R2: On each cycle with `tick1Hz` high the count increases by 1, and it wraps from 0xFFFFFFFF to 0. With no tick and no write the count holds.
- R3: A write to byte offset 0x0C loads the count. If that write comes in the same cycle as a tick, the written value wins.
- R4: Status bit 0 (alarm 1, compare at 0x10) and bit 1 (alarm 2, compare at 0x14) set on the tick edge where the count becomes equal to that alarm's compare value. They stay set until cleared.
- R5: Writing 1 to a status bit at offset 0x00 clears that flag, and writing 0 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R6: `irq` is the OR over both alarms of the flag ANDed with bit 0 of the alarm's configuration word (alarm 1 at 0x04, alarm 2 at 0x08). Bits 1 (periodic tick enable) and 2 (1 Hz select) are stored and read back but never drive `irq`.
- R7: After every accepted write except a zero write to status, `busy` is high for exactly SETTLE_CYCLES clock cycles.
- R8: `ready` is low while `busy` is high. A write presented while `ready` is low changes no register and completes once `ready` returns.
- R9: A write of zero to the status word changes no flag and does not raise `busy`.
- R10: `uninit` is high whenever bits [7:0] of the test word at 0x1C are nonzero. Writing zero to that word drops it.
- R11: Every register reads back at its byte offset (decoded on `addr[4:2]`). The configuration words keep only bits [2:0], and the other words keep all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick1Hz | input | 1 | One-cycle enable once per second from the prescaler |
| wrEn | input | 1 | Write request, held until accepted while `ready` is high |
| addr | input | 5 | Byte offset of the register to write or read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| ready | output | 1 | High when a write will be accepted on the next edge |
| busy | output | 1 | High during the settling window after a write |
| irq | output | 1 | Level alarm interrupt |
| uninit | output | 1 | High while the test word marks the clock as not set up |

## Verification
The assertions assume that `tick1Hz` is a single-cycle pulse from a well-behaved prescaler. They also assume that `wrEn` is held stable until the write is accepted, and that the bus presents word-aligned offsets. The stimulus drives every input on the falling edge and raises the tick for one cycle only. It keeps `wrEn` asserted through the accepting edge and drops it on the following falling edge. The only deliberate collisions are a tick in the same cycle as a count load and a tick in the same cycle as a status clear, which the requirements define.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int unsigned NUM_ALARMS = 2;
  localparam int unsigned CFG_W      = 3;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_CFG_A  = 3'd1,
    SEL_CFG_B  = 3'd2,
    SEL_COUNT  = 3'd3,
    SEL_CMP_A  = 3'd4,
    SEL_CMP_B  = 3'd5,
    SEL_CAL    = 3'd6,
    SEL_TEST   = 3'd7
  } regSel_t;

  // Write strobes from the control side to the datapath.
  typedef struct packed {
    logic                  wrStatus;
    logic [NUM_ALARMS-1:0] wrCfg;
    logic                  wrCount;
    logic [NUM_ALARMS-1:0] wrCmp;
    logic                  wrCal;
    logic                  wrTest;
  } strobe_t;

endpackage

// File: rtl/rtc_bus_ctrl.sv
module rtc_bus_ctrl
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W        = 5,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned SETTLE_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output strobe_t           strb,
  output logic              busy,
  output logic              ready
);

  localparam int unsigned CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYCLES);

  logic [CNT_W-1:0] busyCnt;
  regSel_t          sel;
  logic             accept;
  logic             quietWrite;

  assign sel        = regSel_t'(addr[4:2]);
  assign busy       = (busyCnt != '0);
  assign ready      = !busy;
  assign accept     = wrEn && ready;
  assign quietWrite = (sel == SEL_STATUS) && (wdata == '0);

  always_comb begin
    strb = '0;
    if (accept) begin
      unique case (sel)
        SEL_STATUS: strb.wrStatus = 1'b1;
        SEL_CFG_A:  strb.wrCfg[0] = 1'b1;
        SEL_CFG_B:  strb.wrCfg[1] = 1'b1;
        SEL_COUNT:  strb.wrCount  = 1'b1;
        SEL_CMP_A:  strb.wrCmp[0] = 1'b1;
        SEL_CMP_B:  strb.wrCmp[1] = 1'b1;
        SEL_CAL:    strb.wrCal    = 1'b1;
        SEL_TEST:   strb.wrTest   = 1'b1;
        default:    strb          = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (accept && !quietWrite) begin
      busyCnt <= SETTLE_LOAD;
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  // R7: a settling write opens the busy window
  p_busy_after_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ready && !quietWrite) |=> busy);

  // R7: the window never exceeds its programmed length
  p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= SETTLE_LOAD);

  // R8: no write strobe reaches the datapath while settling
  p_no_strobe_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (strb == '0));

  // R9: a zero write to status leaves the bus idle
  p_quiet_write_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ready && quietWrite) |=> !busy);

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 32,
  parameter logic [7:0]  TEST_INIT = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick1Hz,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              uninit
);

  logic [DATA_W-1:0]     count;
  logic [DATA_W-1:0]     nextCount;
  logic [DATA_W-1:0]     cmpReg [NUM_ALARMS];
  logic [CFG_W-1:0]      cfgReg [NUM_ALARMS];
  logic [DATA_W-1:0]     calReg;
  logic [DATA_W-1:0]     testReg;
  logic [NUM_ALARMS-1:0] flag;
  logic [NUM_ALARMS-1:0] hit;
  logic [NUM_ALARMS-1:0] alarmEn;
  logic                  countStep;

  assign nextCount = count + 1'b1;
  assign countStep = tick1Hz && !strb.wrCount;

  for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alarm
    assign hit[i]     = countStep && (nextCount == cmpReg[i]);
    assign alarmEn[i] = cfgReg[i][0];

    // R4: a flag only rises on a tick edge
    p_flag_needs_tick_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flag[i]) |-> $past(tick1Hz));

    // R5: a flag clears only through a status write with its bit set
    p_flag_clear_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flag[i]) |-> ($past(strb.wrStatus) && $past(wdata[i])));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      calReg  <= '0;
      testReg <= DATA_W'(TEST_INIT);
      flag    <= '0;
      for (int k = 0; k < NUM_ALARMS; k++) begin
        cmpReg[k] <= '0;
        cfgReg[k] <= '0;
      end
    end else begin
      if (strb.wrCount)    count <= wdata;
      else if (tick1Hz)    count <= nextCount;
      if (strb.wrCal)      calReg  <= wdata;
      if (strb.wrTest)     testReg <= wdata;
      for (int k = 0; k < NUM_ALARMS; k++) begin
        if (strb.wrCmp[k]) cmpReg[k] <= wdata;
        if (strb.wrCfg[k]) cfgReg[k] <= wdata[CFG_W-1:0];
        if (hit[k])                             flag[k] <= 1'b1;
        else if (strb.wrStatus && wdata[k])     flag[k] <= 1'b0;
      end
    end
  end

  assign irq    = |(flag & alarmEn);
  assign uninit = |testReg[7:0];

  always_comb begin
    unique case (regSel_t'(addr[4:2]))
      SEL_STATUS: rdata = DATA_W'(flag);
      SEL_CFG_A:  rdata = DATA_W'(cfgReg[0]);
      SEL_CFG_B:  rdata = DATA_W'(cfgReg[1]);
      SEL_COUNT:  rdata = count;
      SEL_CMP_A:  rdata = cmpReg[0];
      SEL_CMP_B:  rdata = cmpReg[1];
      SEL_CAL:    rdata = calReg;
      SEL_TEST:   rdata = testReg;
      default:    rdata = '0;
    endcase
  end

  // R2: the count holds without tick or load
  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!tick1Hz && !strb.wrCount) |=> $stable(count));

  // R2: a tick without a load steps the count by one
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tick1Hz && !strb.wrCount) |=> (count == $past(count) + 1'b1));

  // R6: the interrupt always has a pending flag behind it
  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flag != '0));

  // R9: a zero status write with no tick leaves flags alone
  p_zero_status_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStatus && (wdata[NUM_ALARMS-1:0] == '0) && !tick1Hz) |=> $stable(flag));

endmodule

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core
  import rtc_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W        = 5,
  parameter int unsigned DATA_W        = 32,
  parameter int unsigned SETTLE_CYCLES = 500,
  parameter logic [7:0]  TEST_INIT     = 8'hA5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick1Hz,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              busy,
  output logic              irq,
  output logic              uninit
);

  strobe_t strb;

  rtc_bus_ctrl #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .SETTLE_CYCLES (SETTLE_CYCLES)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrEn  (wrEn),
    .addr  (addr),
    .wdata (wdata),
    .strb  (strb),
    .busy  (busy),
    .ready (ready)
  );

  rtc_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .TEST_INIT (TEST_INIT)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tick1Hz (tick1Hz),
    .strb    (strb),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .uninit  (uninit)
  );

endmodule

// File: tb/test_rtc_alarm_core.sv
`timescale 1ns/1ps
module test_rtc_alarm_core;

  localparam int unsigned SETTLE = 500;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick1Hz = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, busy, irq, uninit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rtc_alarm_core #(.SETTLE_CYCLES(SETTLE)) i_rtc_alarm_core (
    .clk(clk), .rstN(rstN), .tick1Hz(tick1Hz), .wrEn(wrEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready), .busy(busy), .irq(irq),
    .uninit(uninit)
  );

  // {offset, write value, expected readback}
  localparam int NV = 7;
  localparam logic [71:0] VEC [NV] = '{
    {8'h04, 32'hFFFF_FFFF, 32'h0000_0007},
    {8'h08, 32'h0000_0005, 32'h0000_0005},
    {8'h10, 32'h1234_5678, 32'h1234_5678},
    {8'h14, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {8'h18, 32'h0000_ABCD, 32'h0000_ABCD},
    {8'h04, 32'h0000_0000, 32'h0000_0000},
    {8'h08, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  // Returns on the falling edge after the accepting edge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk);
    tick1Hz = 1'b1;
    @(negedge clk);
    tick1Hz = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(5'h0C, v); check(v == 0, "R1 count", v, 0);
    rd(5'h00, v); check(v == 0, "R1 status", v, 0);
    rd(5'h10, v); check(v == 0, "R1 cmp", v, 0);
    rd(5'h1C, v); check(v[7:0] == 8'hA5, "R1 test", v, 32'hA5);
    check(uninit && !busy && !irq && ready, "R1 flags", {uninit, busy, irq, ready}, 32'b1001);

    // R11 readback table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      check(v == VEC[i][31:0], "R11 readback", v, VEC[i][31:0]);
    end

    // R7 settle window length
    wr(5'h18, 32'h1);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check(n == SETTLE, "R7 busy length", n, SETTLE);

    // R8 held write
    wr(5'h18, 32'h2);
    @(negedge clk);
    wrEn = 1'b1; addr = 5'h18; wdata = 32'h77;
    #1;
    check(!ready, "R8 ready low", ready, 0);
    repeat (3) @(negedge clk);
    #1;
    check(rdata == 32'h2, "R8 write held", rdata, 32'h2);
    while (!ready) @(negedge clk);
    @(negedge clk);
    wrEn = 1'b0;
    rd(5'h18, v); check(v == 32'h77, "R8 write lands", v, 32'h77);
    waitIdle();

    // R10 test word
    wr(5'h1C, 32'h0);
    check(!uninit, "R10 uninit cleared", uninit, 0);
    waitIdle();

    // R3 load, R4 flag timing, R6 gating
    wr(5'h0C, 32'd100); waitIdle();
    wr(5'h10, 32'd103); waitIdle();
    wr(5'h04, 32'h1);   waitIdle();
    tick(); rd(5'h0C, v); check(v == 101, "R2 step", v, 101);
    tick(); rd(5'h00, v); check(v == 0, "R4 no early flag", v, 0);
    tick(); rd(5'h00, v); check(v == 1, "R4 flag on match", v, 1);
    check(irq, "R6 irq enabled", irq, 1);
    tick(); rd(5'h00, v); check(v == 1, "R4 sticky", v, 1);

    // R5 write-one-to-clear
    wr(5'h00, 32'h1);
    rd(5'h00, v); check(v == 0, "R5 w1c", v, 0);
    check(!irq, "R6 irq drops", irq, 0);
    waitIdle();

    // R6 masked alarm 2 with tick bits set
    wr(5'h14, 32'd105); waitIdle();
    wr(5'h08, 32'h6);   waitIdle();
    tick();
    rd(5'h00, v); check(v == 2, "R4 alarm2 flag", v, 2);
    check(!irq, "R6 masked", irq, 0);
    wr(5'h08, 32'h1);
    check(irq, "R6 unmasked", irq, 1);
    waitIdle();

    // R9 zero write to status
    wr(5'h00, 32'h0);
    check(!busy, "R9 no busy", busy, 0);
    rd(5'h00, v); check(v == 2, "R9 flags kept", v, 2);

    // R5 set wins over clear
    wr(5'h10, 32'd106); waitIdle();
    @(negedge clk);
    wrEn = 1'b1; addr = 5'h00; wdata = 32'h1; tick1Hz = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick1Hz = 1'b0;
    rd(5'h00, v); check(v == 3, "R5 set beats clear", v, 3);
    waitIdle();

    // R3 load wins over tick
    @(negedge clk);
    wrEn = 1'b1; addr = 5'h0C; wdata = 32'd50; tick1Hz = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick1Hz = 1'b0;
    rd(5'h0C, v); check(v == 50, "R3 load beats tick", v, 50);
    waitIdle();

    // R2 wrap
    wr(5'h0C, 32'hFFFF_FFFE); waitIdle();
    tick(); rd(5'h0C, v); check(v == 32'hFFFF_FFFF, "R2 max", v, 32'hFFFF_FFFF);
    tick(); rd(5'h0C, v); check(v == 0, "R2 wrap", v, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule